// File: doc/BRIEF.md
# Text-Mode VGA Raster and Fetch Timing Generator

This block drives a fixed 640x480 VGA raster from a pixel clock taken directly from a 25.175 MHz oscillator. It also produces the fetch addressing for an 80-column by 24-row character display whose cells are 8 pixels wide and 20 scan lines tall. Since only one display mode exists, nothing has to be programmed. The memories and the pixel serialiser sit outside the block. Two kinds of consumer use its outputs. Text memory takes the cell address. The font memory takes a 5-bit glyph row on its low address bits, inside a 32-row slot. A pixel shifter and a colour latch both take the load strobe.

The block keeps two raster counters that step together. The fetch counter runs `LEAD` clocks ahead of the display counter. That lead covers the latency of the text memory and the font memory, so the first pixel of column 0 reaches the screen at horizontal count 0. Sync and blanking are decoded from the display counter. The address and glyph row come from the fetch counter. A frame counter on the fetch side inverts a slow flash bit. External logic combines that bit with a per-character attribute.

Top module: `text_vga_timing`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks, which is 640+16+96+48 = 800 by default. `hsync_no` is low for exactly H_SYNC clocks, starting at horizontal count H_ACTIVE+H_FP, and is high at every other count.
- R2: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines, which is 480+10+2+33 = 525 by default. `vsync_no` is low for exactly V_SYNC whole lines, starting at line V_ACTIVE+V_FP, and changes only at a line boundary.
- R3: `blank_o` is high exactly when the displayed position is outside the visible area, that is, horizontal count >= H_ACTIVE or line >= V_ACTIVE.
- R4: `load_o` is high for one clock in two cases only. The first is the clock directly before the first pixel of each visible cell, meaning the next horizontal count is a multiple of CELL_W (8), below H_ACTIVE, on a visible line. The second is the last clock of the previous line, ahead of column 0. That gives COLS strobes per visible line and none anywhere else.
- R5: `LEAD` clocks before the first pixel of a cell is displayed, `cell_addr_o` equals row*COLS + column (row-major, so column 0 of row 0 is 0 and the last cell is COLS*ROWS-1). That is LEAD-1 clocks before the strobe for the same cell.
- R6: `glyph_row_o` is sampled at the same clock as the address in R5. It equals the scan line inside the character row, counting 0 to CELL_H-1 (0..19), and returns to 0 at each new character row and at the start of each frame. Values of CELL_H or above (20..31) never appear.
- R7: `flash_o` is 0 after reset. It inverts each time FLASH_FRAMES (32) frames have been fetched, on the clock at which the fetch position returns to the frame origin. That clock is LEAD clocks before the displayed frame begins.
- R8: While reset is held, the display position is LEAD clocks before the frame origin and the fetch position is at the origin. In that state both syncs are high, `blank_o` is high, `load_o` is low, `cell_addr_o` is 0, `glyph_row_o` is 0 and `flash_o` is 0. The first frame after reset is therefore complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| blank_o | output | 1 | High outside the visible area; forces colour to black |
| cell_addr_o | output | AW (11) | Text and colour memory cell address |
| glyph_row_o | output | GLYPH_W (5) | Font row index, low font address bits |
| load_o | output | 1 | Load strobe for pixel shifter and colour latch |
| flash_o | output | 1 | Slow flash phase |

## Verification
Several relations are checked on every cycle by assertions. The syncs only ever occur inside blanking. Vertical sync changes only at line boundaries. Strobes are never adjacent, and each one is followed by a visible pixel. The glyph row stays below the cell height. The flash bit changes only after a fetch frame ends. The fetch counter sits exactly LEAD counts ahead of the display counter at the frame origin. Other properties need the bench's scenarios, which run a reduced geometry over several frames. Those are the exact sync widths and positions, the complete ordered list of strobes with each one's clock, the cell address and glyph row presented LEAD clocks ahead, the flash period, and the state under reset.

// File: rtl/tvg_pkg.sv
package tvg_pkg;
  localparam int unsigned VGA_H_FP    = 16;
  localparam int unsigned VGA_H_SYNC  = 96;
  localparam int unsigned VGA_H_BP    = 48;
  localparam int unsigned VGA_V_FP    = 10;
  localparam int unsigned VGA_V_SYNC  = 2;
  localparam int unsigned VGA_V_BP    = 33;
  localparam int unsigned TXT_COLS    = 80;
  localparam int unsigned TXT_ROWS    = 24;
  localparam int unsigned TXT_CELL_W  = 8;
  localparam int unsigned TXT_CELL_H  = 20;
  localparam int unsigned GLYPH_ROW_W = 5;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tvg_raster_cnt.sv
module tvg_raster_cnt #(
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned V_TOTAL = 525,
  parameter int unsigned INIT_H  = 0,
  parameter int unsigned INIT_V  = 0,
  localparam int unsigned HW = tvg_pkg::bits_for(H_TOTAL),
  localparam int unsigned VW = tvg_pkg::bits_for(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          line_end_o,
  output logic          frame_end_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_INIT = HW'(INIT_H);
  localparam logic [VW-1:0] V_INIT = VW'(INIT_V);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= H_INIT;
      v_q <= V_INIT;
    end else if (h_q == H_LAST) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o         = h_q;
  assign v_o         = v_q;
  assign line_end_o  = (h_q == H_LAST);
  assign frame_end_o = (h_q == H_LAST) && (v_q == V_LAST);
endmodule

// File: rtl/tvg_cell_gen.sv
module tvg_cell_gen #(
  parameter int unsigned COLS    = 80,
  parameter int unsigned ROWS    = 24,
  parameter int unsigned CELL_W  = 8,
  parameter int unsigned CELL_H  = 20,
  parameter int unsigned GLYPH_W = 5,
  parameter int unsigned HW      = 10,
  parameter int unsigned VW      = 10,
  localparam int unsigned AW = tvg_pkg::bits_for(COLS * ROWS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HW-1:0]      h_i,
  input  logic [VW-1:0]      v_i,
  input  logic               line_end_i,
  input  logic               frame_end_i,
  output logic [AW-1:0]      cell_addr_o,
  output logic [GLYPH_W-1:0] glyph_row_o
);
  localparam logic [HW-1:0]      H_ACT   = HW'(COLS * CELL_W);
  localparam logic [VW-1:0]      V_ACT   = VW'(ROWS * CELL_H);
  localparam logic [GLYPH_W-1:0] G_LAST  = GLYPH_W'(CELL_H - 1);
  localparam logic [AW-1:0]      ROW_INC = AW'(COLS);
  localparam logic [HW-1:0]      CW      = HW'(CELL_W);

  logic [AW-1:0]      row_base_q;
  logic [GLYPH_W-1:0] glyph_q;
  logic [HW-1:0]      col;

  // row base stepped by COLS per character row: no multiplier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_base_q <= '0;
      glyph_q    <= '0;
    end else if (frame_end_i) begin
      row_base_q <= '0;
      glyph_q    <= '0;
    end else if (line_end_i && (v_i < V_ACT)) begin
      if (glyph_q == G_LAST) begin
        glyph_q    <= '0;
        row_base_q <= row_base_q + ROW_INC;
      end else begin
        glyph_q <= glyph_q + 1'b1;
      end
    end
  end

  assign col         = h_i / CW;
  assign cell_addr_o = row_base_q + AW'(col);
  assign glyph_row_o = glyph_q;

  a_r6_glyph_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, glyph_q} < (GLYPH_W + 1)'(CELL_H));
  a_r6_glyph_frame_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i == '0) |-> (glyph_q == '0));
  a_r5_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((h_i < H_ACT) && (v_i < V_ACT)) |-> (cell_addr_o < AW'(COLS * ROWS)));
endmodule

// File: rtl/tvg_flash.sv
module tvg_flash #(
  parameter int unsigned FLASH_FRAMES = 32,
  localparam int unsigned FW = tvg_pkg::bits_for(FLASH_FRAMES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_end_i,
  output logic flash_o
);
  localparam logic [FW-1:0] F_LAST = FW'(FLASH_FRAMES - 1);

  logic [FW-1:0] cnt_q;
  logic          flash_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      flash_q <= 1'b0;
    end else if (frame_end_i) begin
      if (cnt_q == F_LAST) begin
        cnt_q   <= '0;
        flash_q <= ~flash_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign flash_o = flash_q;

  a_r7_flash_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flash_q) |-> $past(frame_end_i));
endmodule

// File: rtl/text_vga_timing.sv
module text_vga_timing #(
  parameter int unsigned COLS         = tvg_pkg::TXT_COLS,
  parameter int unsigned ROWS         = tvg_pkg::TXT_ROWS,
  parameter int unsigned CELL_W       = tvg_pkg::TXT_CELL_W,
  parameter int unsigned CELL_H       = tvg_pkg::TXT_CELL_H,
  parameter int unsigned GLYPH_W      = tvg_pkg::GLYPH_ROW_W,
  parameter int unsigned H_FP         = tvg_pkg::VGA_H_FP,
  parameter int unsigned H_SYNC       = tvg_pkg::VGA_H_SYNC,
  parameter int unsigned H_BP         = tvg_pkg::VGA_H_BP,
  parameter int unsigned V_FP         = tvg_pkg::VGA_V_FP,
  parameter int unsigned V_SYNC       = tvg_pkg::VGA_V_SYNC,
  parameter int unsigned V_BP         = tvg_pkg::VGA_V_BP,
  parameter int unsigned LEAD         = 3,
  parameter int unsigned FLASH_FRAMES = 32,
  localparam int unsigned AW = tvg_pkg::bits_for(COLS * ROWS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               hsync_no,
  output logic               vsync_no,
  output logic               blank_o,
  output logic [AW-1:0]      cell_addr_o,
  output logic [GLYPH_W-1:0] glyph_row_o,
  output logic               load_o,
  output logic               flash_o
);
  localparam int unsigned H_ACTIVE = COLS * CELL_W;
  localparam int unsigned V_ACTIVE = ROWS * CELL_H;
  localparam int unsigned H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int unsigned V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int unsigned HW = tvg_pkg::bits_for(H_TOTAL);
  localparam int unsigned VW = tvg_pkg::bits_for(V_TOTAL);

  localparam logic [HW-1:0] H_ACT_L  = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HS_BEG_L = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END_L = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_ACT_L  = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VS_BEG_L = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END_L = VW'(V_ACTIVE + V_FP + V_SYNC);
  localparam logic [HW-1:0] CW_L     = HW'(CELL_W);
  localparam logic [HW-1:0] LEAD_L   = HW'(LEAD);

  logic [HW-1:0] dh, fh, nh;
  logic [VW-1:0] dv, fv, nv;
  logic          d_line_end, d_frame_end, f_line_end, f_frame_end;

  // display side starts LEAD clocks before the origin, fetch side at it
  tvg_raster_cnt #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .INIT_H(H_TOTAL - LEAD), .INIT_V(V_TOTAL - 1)
  ) i_disp_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_o(dh), .v_o(dv),
    .line_end_o(d_line_end), .frame_end_o(d_frame_end)
  );

  tvg_raster_cnt #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .INIT_H(0), .INIT_V(0)
  ) i_fetch_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_o(fh), .v_o(fv),
    .line_end_o(f_line_end), .frame_end_o(f_frame_end)
  );

  tvg_cell_gen #(
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
    .GLYPH_W(GLYPH_W), .HW(HW), .VW(VW)
  ) i_cell_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_i(fh), .v_i(fv),
    .line_end_i(f_line_end), .frame_end_i(f_frame_end),
    .cell_addr_o(cell_addr_o), .glyph_row_o(glyph_row_o)
  );

  tvg_flash #(.FLASH_FRAMES(FLASH_FRAMES)) i_flash (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_end_i(f_frame_end), .flash_o(flash_o)
  );

  assign hsync_no = !((dh >= HS_BEG_L) && (dh < HS_END_L));
  assign vsync_no = !((dv >= VS_BEG_L) && (dv < VS_END_L));
  assign blank_o  = (dh >= H_ACT_L) || (dv >= V_ACT_L);

  // strobe on the clock before the next displayed pixel opens a cell
  always_comb begin
    nh = d_line_end ? '0 : dh + 1'b1;
    nv = d_frame_end ? '0 : (d_line_end ? dv + 1'b1 : dv);
  end
  assign load_o = (nh < H_ACT_L) && (nv < V_ACT_L) && ((nh % CW_L) == '0);

  a_r1_hsync_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_no |-> blank_o);
  a_r2_vsync_line_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vsync_no) |-> $past(d_line_end));
  a_r3_visible_no_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_o |-> (hsync_no && vsync_no));
  a_r4_load_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  a_r4_load_then_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !blank_o);
  a_r5_fetch_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dh == '0) && (dv == '0)) |-> ((fh == LEAD_L) && (fv == '0)));
endmodule

// File: tb/test_text_vga_timing.sv
module test_text_vga_timing;
  localparam int COLS = 4, ROWS = 3, CW = 8, CH = 4, GW = 5;
  localparam int HFP = 4, HSY = 6, HBP = 6, VFP = 2, VSY = 2, VBP = 3;
  localparam int LEAD = 3, FF = 4, NFR = 9;
  localparam int HA = COLS * CW, VA = ROWS * CH;
  localparam int HT = HA + HFP + HSY + HBP, VT = VA + VFP + VSY + VBP;
  localparam int FRAME = HT * VT;
  localparam int RUN = NFR * FRAME;
  localparam int AW = tvg_pkg::bits_for(COLS * ROWS + 1);

  typedef struct { int t; int addr; int glyph; } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic hsync_no, vsync_no, blank_o, load_o, flash_o;
  logic [AW-1:0] cell_addr_o;
  logic [GW-1:0] glyph_row_o;

  int checks = 0, fails = 0, t = 0;
  bit done = 1'b0;
  exp_t q[$];
  int addr_log[RUN + 1];
  int glyph_log[RUN + 1];

  always #4 clk = ~clk;

  text_vga_timing #(
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CW), .CELL_H(CH), .GLYPH_W(GW),
    .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP),
    .LEAD(LEAD), .FLASH_FRAMES(FF)
  ) i_text_vga_timing (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_no(hsync_no), .vsync_no(vsync_no),
    .blank_o(blank_o), .cell_addr_o(cell_addr_o), .glyph_row_o(glyph_row_o),
    .load_o(load_o), .flash_o(flash_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, exp, t);
    end
  endtask

  // driver: expected strobe clock, address and glyph row of every visible cell
  task automatic push_frames(input int n);
    for (int f = 0; f < n; f++)
      for (int v = 0; v < VA; v++)
        for (int c = 0; c < COLS; c++) begin
          exp_t e;
          e.t     = f * FRAME + v * HT + c * CW - 1 + LEAD;
          e.addr  = (v / CH) * COLS + c;
          e.glyph = v % CH;
          q.push_back(e);
        end
  endtask

  always @(posedge clk) if (rst_ni) t <= t + 1;

  // monitor
  always @(negedge clk) begin
    if (rst_ni && t >= 1 && t < RUN) begin
      int dp, dh, dv;
      bit e_hs, e_vs, e_bl, e_fl;
      dp = (t + FRAME - LEAD) % FRAME;
      dh = dp % HT;
      dv = dp / HT;
      e_hs = !(dh >= HA + HFP && dh < HA + HFP + HSY);
      e_vs = !(dv >= VA + VFP && dv < VA + VFP + VSY);
      e_bl = (dh >= HA) || (dv >= VA);
      e_fl = ((t / FRAME) / FF) % 2 == 1;
      chk(hsync_no == e_hs, "R1 hsync", int'(hsync_no), int'(e_hs));
      chk(vsync_no == e_vs, "R2 vsync", int'(vsync_no), int'(e_vs));
      chk(blank_o == e_bl, "R3 blank", int'(blank_o), int'(e_bl));
      chk(flash_o == e_fl, "R7 flash", int'(flash_o), int'(e_fl));
      addr_log[t]  = int'(cell_addr_o);
      glyph_log[t] = int'(glyph_row_o);
      if (load_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4 unexpected load", t, -1);
        end else begin
          exp_t e;
          int ft;
          e  = q.pop_front();
          ft = t - (LEAD - 1);
          chk(t == e.t, "R4 load clock", t, e.t);
          if (ft >= 1) begin
            chk(addr_log[ft] == e.addr, "R5 cell address", addr_log[ft], e.addr);
            chk(glyph_log[ft] == e.glyph, "R6 glyph row", glyph_log[ft], e.glyph);
          end
        end
      end
    end
  end

  initial begin
    push_frames(NFR);
    repeat (3) @(negedge clk);
    // R8: state held under reset
    chk(hsync_no == 1'b1, "R8 hsync in reset", int'(hsync_no), 1);
    chk(vsync_no == 1'b1, "R8 vsync in reset", int'(vsync_no), 1);
    chk(blank_o == 1'b1, "R8 blank in reset", int'(blank_o), 1);
    chk(load_o == 1'b0, "R8 load in reset", int'(load_o), 0);
    chk(cell_addr_o == '0, "R8 address in reset", int'(cell_addr_o), 0);
    chk(glyph_row_o == '0, "R8 glyph in reset", int'(glyph_row_o), 0);
    chk(flash_o == 1'b0, "R8 flash in reset", int'(flash_o), 0);
    #1 rst_ni = 1'b1;
    repeat (RUN + 2) @(negedge clk);
    // R4: every visible cell got its strobe
    chk(q.size() == 0, "R4 missed loads", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (RUN + 2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", t, RUN);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule